// File: doc/BRIEF.md
# Remote Terminal Command Word Decoder

This block sits behind the word receiver of a remote terminal on a command/response serial avionics bus. Each received word arrives already checked for sync, Manchester coding and parity. A strobe marks each word, and a flag tells a command word from a data word. The decoder checks the terminal address field against this terminal's strapped address and against the broadcast address. Commands that match are split into direction, subaddress and count. Commands whose subaddress field is all zeros or all ones are classed as mode commands. The block then reports the decoded command to the host with a one-clock strobe.

Mode commands are only reported: a terminal reset code, for example, is passed to the host as a code and triggers nothing inside the block. Mode codes whose top bit is set carry one data word, and the block moves that word without interpreting it. A transmit-direction code raises a memory read request so the host-defined word (vector, self-test result) can be sent. A receive-direction code arms a write, and the next data word on the bus (a synchronize value, for example) is handed to memory. Broadcast commands are accepted only while the active-low broadcast enable is low, and an accepted broadcast is flagged to the host.

Top module: `rt_cmd_decoder`

## Requirements
- R1: A valid command word whose bits 15:11 equal `own_addr` produces `cmd_stb` high for exactly the cycle after the word is sampled. In that cycle `cmd_tx` = bit 10, `cmd_sub` = bits 9:5 and `cmd_cnt` = bits 4:0, and these fields hold until the next accepted command.
- R2: A command word whose address is neither `own_addr` nor 31 produces no strobe, no mode strobe and no memory request, and leaves every held output unchanged. A word with `word_valid` low has the same lack of effect.
- R3: A command word with address 31 is accepted while `bcast_en_n` is low, for both mode and non-mode commands. The block then raises `cmd_bcast`, which holds until the next accepted command. An accepted addressed command clears it.
- R4: While `bcast_en_n` is high, an address-31 command is ignored: no strobe, no request, no change to `cmd_bcast`, and no write armed.
- R5: An accepted command whose subaddress is 0 or 31 sets `cmd_is_mode`. It also pulses `mode_stb` together with `cmd_stb`, with `mode_code` equal to bits 4:0. Any other subaddress clears `cmd_is_mode` and gives no `mode_stb`.
- R6: Mode codes 0 to 15, including the terminal reset code 8, are only reported through `mode_stb`/`mode_code`. They raise no memory request and do not disturb later decoding.
- R7: An accepted receive-direction (bit 10 = 0) mode command with a code of 16 or more arms a write. The next valid data word (`word_is_cmd` = 0) then pulses `mem_wr` one cycle later, with `mem_wdata` equal to that word and `mem_addr` = {0, code}. Only one write follows each arming.
- R8: An accepted transmit-direction (bit 10 = 1) mode command with a code of 16 or more pulses `mem_rd` in the same cycle as `cmd_stb`, with `mem_addr` = {1, code}.
- R9: A data word with no write armed produces no `mem_wr`. Any valid command word, accepted or not, cancels an armed write.
- R10: After reset all strobes and requests are low and `cmd_bcast` is low.
- R11: Non-mode commands raise neither `mem_rd` nor `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | Received word strobe |
| word_is_cmd | input | 1 | 1 = command word, 0 = data word |
| word_data | input | 16 | Received word |
| own_addr | input | 5 | This terminal's address |
| bcast_en_n | input | 1 | Active-low broadcast enable |
| cmd_stb | output | 1 | One-cycle accepted-command pulse |
| cmd_tx | output | 1 | Direction of last accepted command |
| cmd_sub | output | 5 | Subaddress/mode field |
| cmd_cnt | output | 5 | Word count/mode code field |
| cmd_is_mode | output | 1 | Last accepted command was a mode command |
| cmd_bcast | output | 1 | Last accepted command was broadcast |
| mode_stb | output | 1 | Mode command pulse for the host |
| mode_code | output | 5 | Mode code reported to the host |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 6 | {direction, mode code} memory index |
| mem_wdata | output | 16 | Data word to write |

## Verification
The hardest case to reach is the armed-write window. A receive mode command with a data-bearing code must be followed by a data word, and the write must happen exactly once. A command word arriving before the data word, including one for another terminal, must cancel the write. The vector table builds these sequences back to back: arm then write then a stray data word, and arm then an interrupting command then a data word. It also sends an ignored broadcast while `cmd_bcast` is already set, so that state left untouched shows at the ports.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;
   // memory action implied by a decoded command
   typedef enum logic [1:0] {
      MACT_NONE = 2'd0,
      MACT_READ = 2'd1,
      MACT_ARM  = 2'd2
   } mact_e;

   function automatic mact_e mact_of(input logic is_mode,
                                     input logic data_bit,
                                     input logic tx);
      if (!is_mode || !data_bit) return MACT_NONE;
      return tx ? MACT_READ : MACT_ARM;
   endfunction
endpackage

// File: rtl/rt_cmd_classify.sv
module rt_cmd_classify
   import rt_cmd_pkg::*;
#(
   parameter int ADDR_W         = 5,
   parameter int SUB_W          = 5,
   parameter int CNT_W          = 5,
   parameter int BCAST_ADDR     = 31,
   parameter bit MODE_SA_MAX_EN = 1'b1,
   localparam int WORD_W        = ADDR_W + 1 + SUB_W + CNT_W
) (
   input  logic              valid,
   input  logic              is_cmd,
   input  logic [WORD_W-1:0] word,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              bcast_en_n,
   output logic              hit,
   output logic              bcast,
   output logic              tx,
   output logic [SUB_W-1:0]  sub,
   output logic [CNT_W-1:0]  cnt,
   output logic              is_mode,
   output mact_e             mact
);
   localparam logic [ADDR_W-1:0] BC_A = ADDR_W'(BCAST_ADDR);

   logic [ADDR_W-1:0] addr;
   logic              to_own, to_bc;

   assign addr = word[WORD_W-1 -: ADDR_W];
   assign tx   = word[SUB_W+CNT_W];
   assign sub  = word[CNT_W +: SUB_W];
   assign cnt  = word[CNT_W-1:0];

   generate
      if (MODE_SA_MAX_EN) begin : g_mode_both
         assign is_mode = (sub == '0) || (&sub);
      end else begin : g_mode_zero
         assign is_mode = (sub == '0);
      end
   endgenerate

   assign to_bc  = (addr == BC_A);
   assign to_own = (addr == own_addr) && !to_bc;
   assign bcast  = to_bc;
   assign hit    = valid && is_cmd && (to_own || (to_bc && !bcast_en_n));
   assign mact   = mact_of(is_mode, cnt[CNT_W-1], tx);
endmodule

// File: rtl/rt_mode_data_track.sv
module rt_mode_data_track
   import rt_cmd_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_seen,
   input  logic              cmd_hit,
   input  mact_e             cmd_mact,
   input  logic [CNT_W-1:0]  cmd_code,
   input  logic              data_valid,
   input  logic [WORD_W-1:0] data_word,
   output logic              wr_stb,
   output logic [CNT_W-1:0]  wr_code,
   output logic [WORD_W-1:0] wr_data
);
   logic             armed;
   logic [CNT_W-1:0] arm_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         arm_code <= '0;
         wr_stb   <= 1'b0;
         wr_code  <= '0;
         wr_data  <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (cmd_seen) begin
            armed <= cmd_hit && (cmd_mact == MACT_ARM);
            if (cmd_hit) arm_code <= cmd_code;
         end else if (data_valid && armed) begin
            armed   <= 1'b0;
            wr_stb  <= 1'b1;
            wr_code <= arm_code;
            wr_data <= data_word;
         end
      end
   end

   // R7: every write consumes the arming, so two writes never follow back to back
   assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   // R9: a command word in the cycle before leaves no write
   assert_cmd_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_seen |=> !wr_stb);
endmodule

// File: rtl/rt_cmd_decoder.sv
module rt_cmd_decoder
   import rt_cmd_pkg::*;
#(
   parameter int ADDR_W         = 5,
   parameter int SUB_W          = 5,
   parameter int CNT_W          = 5,
   parameter int BCAST_ADDR     = 31,
   parameter bit MODE_SA_MAX_EN = 1'b1,
   localparam int WORD_W        = ADDR_W + 1 + SUB_W + CNT_W,
   localparam int MADDR_W       = CNT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_valid,
   input  logic               word_is_cmd,
   input  logic [WORD_W-1:0]  word_data,
   input  logic [ADDR_W-1:0]  own_addr,
   input  logic               bcast_en_n,
   output logic               cmd_stb,
   output logic               cmd_tx,
   output logic [SUB_W-1:0]   cmd_sub,
   output logic [CNT_W-1:0]   cmd_cnt,
   output logic               cmd_is_mode,
   output logic               cmd_bcast,
   output logic               mode_stb,
   output logic [CNT_W-1:0]   mode_code,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0]  mem_wdata
);
   generate
      if (BCAST_ADDR < 0 || BCAST_ADDR >= (1 << ADDR_W)) begin : g_bad_bcast
         $error("BCAST_ADDR does not fit in ADDR_W bits");
      end
      if (CNT_W < 1 || SUB_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("field widths must be positive");
      end
   endgenerate

   logic             c_hit, c_bcast, c_tx, c_mode;
   logic [SUB_W-1:0] c_sub;
   logic [CNT_W-1:0] c_cnt;
   mact_e            c_mact;
   logic [CNT_W-1:0] w_code;

   rt_cmd_classify #(
      .ADDR_W(ADDR_W), .SUB_W(SUB_W), .CNT_W(CNT_W),
      .BCAST_ADDR(BCAST_ADDR), .MODE_SA_MAX_EN(MODE_SA_MAX_EN)
   ) u_classify (
      .valid(word_valid), .is_cmd(word_is_cmd), .word(word_data),
      .own_addr(own_addr), .bcast_en_n(bcast_en_n),
      .hit(c_hit), .bcast(c_bcast), .tx(c_tx), .sub(c_sub), .cnt(c_cnt),
      .is_mode(c_mode), .mact(c_mact)
   );

   rt_mode_data_track #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_track (
      .clk(clk), .rst_n(rst_n),
      .cmd_seen(word_valid && word_is_cmd), .cmd_hit(c_hit),
      .cmd_mact(c_mact), .cmd_code(c_cnt),
      .data_valid(word_valid && !word_is_cmd), .data_word(word_data),
      .wr_stb(mem_wr), .wr_code(w_code), .wr_data(mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_stb     <= 1'b0;
         cmd_tx      <= 1'b0;
         cmd_sub     <= '0;
         cmd_cnt     <= '0;
         cmd_is_mode <= 1'b0;
         cmd_bcast   <= 1'b0;
         mode_stb    <= 1'b0;
         mode_code   <= '0;
         mem_rd      <= 1'b0;
      end else begin
         cmd_stb  <= c_hit;
         mode_stb <= c_hit && c_mode;
         mem_rd   <= c_hit && (c_mact == MACT_READ);
         if (c_hit) begin
            cmd_tx      <= c_tx;
            cmd_sub     <= c_sub;
            cmd_cnt     <= c_cnt;
            cmd_is_mode <= c_mode;
            cmd_bcast   <= c_bcast;
            if (c_mode) mode_code <= c_cnt;
         end
      end
   end

   assign mem_addr = mem_wr ? {1'b0, w_code} : {cmd_tx, cmd_cnt};

   assert_mode_with_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_stb |-> (cmd_stb && cmd_is_mode));
   assert_bcast_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && cmd_bcast) |-> $past(!bcast_en_n));
   assert_read_is_tx_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (cmd_stb && cmd_tx && cmd_is_mode && cmd_cnt[CNT_W-1]));
   assert_one_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));
   assert_low_codes_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && !cmd_cnt[CNT_W-1]) |-> !mem_rd);
endmodule

// File: tb/rt_cmd_decoder_test.sv
module rt_cmd_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_valid = 1'b0, word_is_cmd = 1'b0, bcast_en_n = 1'b0;
   logic [15:0] word_data = '0;
   logic [4:0]  own_addr = 5'd5;
   logic        cmd_stb, cmd_tx, cmd_is_mode, cmd_bcast, mode_stb, mem_rd, mem_wr;
   logic [4:0]  cmd_sub, cmd_cnt, mode_code;
   logic [5:0]  mem_addr;
   logic [15:0] mem_wdata;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   rt_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_is_cmd(word_is_cmd),
      .word_data(word_data), .own_addr(own_addr), .bcast_en_n(bcast_en_n),
      .cmd_stb(cmd_stb), .cmd_tx(cmd_tx), .cmd_sub(cmd_sub), .cmd_cnt(cmd_cnt),
      .cmd_is_mode(cmd_is_mode), .cmd_bcast(cmd_bcast), .mode_stb(mode_stb),
      .mode_code(mode_code), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   typedef struct packed {
      logic        vld, cmd, en_n;
      logic [15:0] w;
      logic        stb, mode, bc, rd, wr;
      logic [5:0]  ma;
   } vec_t;

   // own address 5; word = addr<<11 | tx<<10 | sub<<5 | cnt
   localparam vec_t TBL [15] = '{
      '{1,1,0,16'h2864, 1,0,0,0,0, 6'h00},  // R1 addressed receive
      '{1,1,0,16'h3064, 0,0,0,0,0, 6'h00},  // R2 other terminal
      '{1,1,0,16'hF862, 1,0,1,0,0, 6'h00},  // R3 broadcast accepted
      '{1,1,1,16'hF862, 0,0,1,0,0, 6'h00},  // R4 broadcast disabled
      '{1,1,0,16'h2C02, 1,1,0,0,0, 6'h00},  // R5 mode code 2
      '{1,1,0,16'h2FE8, 1,1,0,0,0, 6'h00},  // R6 reset code via sub 31
      '{1,1,0,16'h2C10, 1,1,0,1,0, 6'h30},  // R8 vector read
      '{1,1,0,16'h2FF3, 1,1,0,1,0, 6'h33},  // R8 self-test read
      '{1,1,0,16'hF811, 1,1,1,0,0, 6'h00},  // R3 broadcast sync arms
      '{1,0,0,16'hBEEF, 0,0,1,0,1, 6'h11},  // R7 write
      '{1,0,0,16'h1234, 0,0,1,0,0, 6'h00},  // R9 no second write
      '{1,1,0,16'h2811, 1,1,0,0,0, 6'h00},  // R7 arm
      '{1,1,0,16'h2861, 1,0,0,0,0, 6'h00},  // R9/R11 cancel by command
      '{1,0,0,16'h5555, 0,0,0,0,0, 6'h00},  // R9 no write
      '{0,1,0,16'hF862, 0,0,0,0,0, 6'h00}   // R2 invalid strobe
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic c, input logic en, input logic [15:0] w);
      @(negedge clk);
      word_valid = v; word_is_cmd = c; bcast_en_n = en; word_data = w;
      @(posedge clk); #2;
      word_valid = 1'b0;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R10 stb", cmd_stb, 0); chk("R10 bc", cmd_bcast, 0);
      chk("R10 rd", mem_rd, 0);   chk("R10 wr", mem_wr, 0);
      chk("R10 mode", mode_stb, 0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < 15; i++) begin
         drive(TBL[i].vld, TBL[i].cmd, TBL[i].en_n, TBL[i].w);
         chk($sformatf("R1/R2/R4 stb row%0d", i), cmd_stb, TBL[i].stb);
         chk($sformatf("R5 mode row%0d", i), mode_stb, TBL[i].mode);
         chk($sformatf("R3 bcast row%0d", i), cmd_bcast, TBL[i].bc);
         chk($sformatf("R8 rd row%0d", i), mem_rd, TBL[i].rd);
         chk($sformatf("R7 wr row%0d", i), mem_wr, TBL[i].wr);
         if (TBL[i].stb) begin
            chk($sformatf("R1 fields row%0d", i), {cmd_tx, cmd_sub, cmd_cnt},
                TBL[i].w[10:0]);
            chk($sformatf("R5 class row%0d", i), cmd_is_mode,
                (TBL[i].w[9:5] == 5'd0) || (TBL[i].w[9:5] == 5'd31));
         end
         if (TBL[i].mode) chk($sformatf("R6 code row%0d", i), mode_code, TBL[i].w[4:0]);
         if (TBL[i].rd || TBL[i].wr) chk($sformatf("R7/R8 addr row%0d", i), mem_addr, TBL[i].ma);
         if (TBL[i].wr) chk($sformatf("R7 data row%0d", i), mem_wdata, TBL[i].w);
      end

      // R9: a command for another terminal also cancels an armed write
      drive(1, 1, 0, 16'h2812);
      chk("R7 arm stb", cmd_stb, 1);
      drive(1, 1, 0, 16'h3064);
      chk("R2 foreign stb", cmd_stb, 0);
      drive(1, 0, 0, 16'hA5A5);
      chk("R9 foreign cancel", mem_wr, 0);

      // R7: arming survives idle cycles until the data word
      drive(1, 1, 0, 16'h281F);
      drive(0, 0, 0, 16'h0000);
      drive(1, 0, 0, 16'h0F0F);
      chk("R7 late wr", mem_wr, 1);
      chk("R7 late addr", mem_addr, 6'h1F);
      chk("R7 late data", mem_wdata, 16'h0F0F);

      // R10: reset mid-run clears held state
      drive(1, 1, 0, 16'hF862);
      chk("R3 bc set", cmd_bcast, 1);
      @(negedge clk); rst_n = 1'b0; #2;
      chk("R10 bc cleared", cmd_bcast, 0);
      chk("R10 stb cleared", cmd_stb, 0);
      @(negedge clk); rst_n = 1'b1;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule